// File: doc/BRIEF.md
# Atomic Byte Test-and-Set Engine

This block sits between a requester and a byte-wide memory port and performs one indivisible read-modify-write. A one-cycle start pulse with a byte address launches the sequence. The engine fetches the byte and records whether it was all zeros. It then writes the same byte back to the same address with its most significant bit forced high and the lower bits untouched. A lock line stays high over the whole exchange, so the memory arbiter can keep every other master out between the read and the write.

Software uses it as a semaphore primitive. A zero byte means the resource was free and has now been claimed, and the flag output reports that. A nonzero byte means another owner already holds it. Both memory channels use valid/ready style signalling. The request channel carries address, write enable and write data. The read response returns on its own valid strobe, which the engine accepts whenever it is waiting. A write counts as complete when its request is accepted.

Top module: `byte_tas_engine`

## Requirements
- R1: While reset is held and immediately after, busy, done, lock, request valid and the flag output are all 0.
- R2: A start pulse seen while idle raises busy on the next cycle and issues a read request (write enable 0) carrying the address sampled with the pulse.
- R3: Once a request is raised it stays raised, with address, write enable and write data unchanged, until the cycle in which ready is high.
- R4: When the read data returns, the flag output becomes 1 if every bit of the returned byte is 0, and 0 otherwise. It is valid no later than the done pulse.
- R5: The write request targets the same address and carries the returned byte OR 0x80: bit 7 is set to 1 and bits 6..0 are copied unchanged.
- R6: Lock is high from the cycle the read request is raised through the cycle the write request is accepted. It is low at all other times, including the done cycle.
- R7: Done is a single-cycle pulse in the cycle after the write is accepted. Busy falls in the cycle after done.
- R8: A start pulse while busy is ignored: the address in use does not change and no extra memory access is made.
- R9: A read response strobe arriving while no read is outstanding is ignored. Between operations the flag output holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| addr_i | input | ADDR_W | Byte address, sampled with start_i |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| flag_o | output | 1 | 1 if the byte read by the last operation was zero |
| mem_lock_o | output | 1 | Keeps the memory arbiter on this engine |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | 1 for the write-back, 0 for the read |
| mem_req_addr_o | output | ADDR_W | Request address |
| mem_req_wdata_o | output | DATA_W | Write-back byte |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | DATA_W | Read data |

## Verification
A corrupted sequencer state shows up at the ports within one clock. A spurious or missing lock, a request with the wrong write enable, or a done pulse without a preceding write acceptance each mismatch the reference on the very next compare. A wrongly captured byte cannot stay hidden until the next operation: it shows on the write data in the cycle the write request appears, and in the flag by the done pulse. Stalled ready and delayed responses stretch each phase, so a state that skips a wait or holds too long diverges in the first stalled cycle.

// File: rtl/tas_pkg.sv
package tas_pkg;

   typedef enum logic [2:0] {
      TAS_IDLE    = 3'd0,
      TAS_RD_REQ  = 3'd1,
      TAS_RD_WAIT = 3'd2,
      TAS_WR_REQ  = 3'd3,
      TAS_DONE    = 3'd4
   } tas_state_e;

   function automatic logic tas_is_locked(tas_state_e s);
      return (s == TAS_RD_REQ) || (s == TAS_RD_WAIT) || (s == TAS_WR_REQ);
   endfunction

   function automatic logic tas_is_request(tas_state_e s);
      return (s == TAS_RD_REQ) || (s == TAS_WR_REQ);
   endfunction

endpackage

// File: rtl/tas_fsm.sv
module tas_fsm
   import tas_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       req_ready_i,
   input  logic       rsp_valid_i,
   output tas_state_e state_o,
   output logic       accept_o,
   output logic       capture_o
);

   tas_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         TAS_IDLE:    if (start_i)     state_d = TAS_RD_REQ;
         TAS_RD_REQ:  if (req_ready_i) state_d = TAS_RD_WAIT;
         TAS_RD_WAIT: if (rsp_valid_i) state_d = TAS_WR_REQ;
         TAS_WR_REQ:  if (req_ready_i) state_d = TAS_DONE;
         TAS_DONE:                     state_d = TAS_IDLE;
         default:                      state_d = TAS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= TAS_IDLE;
      else        state_q <= state_d;
   end

   assign state_o   = state_q;
   assign accept_o  = (state_q == TAS_IDLE) && start_i;
   assign capture_o = (state_q == TAS_RD_WAIT) && rsp_valid_i;

endmodule

// File: rtl/tas_datapath.sv
module tas_datapath #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 8,
   parameter bit REG_MERGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic              capture_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] rsp_data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              zero_o
);

   localparam int                SET_BIT  = DATA_W - 1;
   localparam logic [DATA_W-1:0] SET_MASK = DATA_W'(1) << SET_BIT;

   logic [ADDR_W-1:0] addr_q;
   logic              zero_q;

   generate
      if (DATA_W < 2 || ADDR_W < 1) begin : g_bad_params
         $error("tas_datapath: DATA_W must be at least 2 and ADDR_W at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         zero_q <= 1'b0;
      end else begin
         if (accept_i)  addr_q <= addr_i;
         if (capture_i) zero_q <= (rsp_data_i == '0);
      end
   end

   generate
      if (REG_MERGE) begin : g_merge_reg
         logic [DATA_W-1:0] wdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         wdata_q <= '0;
            else if (capture_i) wdata_q <= rsp_data_i | SET_MASK;
         end
         assign wdata_o = wdata_q;
      end else begin : g_merge_comb
         logic [DATA_W-1:0] byte_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         byte_q <= '0;
            else if (capture_i) byte_q <= rsp_data_i;
         end
         assign wdata_o = byte_q | SET_MASK;
      end
   endgenerate

   assign addr_o = addr_q;
   assign zero_o = zero_q;

endmodule

// File: rtl/byte_tas_engine.sv
module byte_tas_engine
   import tas_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 8,
   parameter bit REG_MERGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              flag_o,
   output logic              mem_lock_o,
   output logic              mem_req_valid_o,
   input  logic              mem_req_ready_i,
   output logic              mem_req_we_o,
   output logic [ADDR_W-1:0] mem_req_addr_o,
   output logic [DATA_W-1:0] mem_req_wdata_o,
   input  logic              mem_rsp_valid_i,
   input  logic [DATA_W-1:0] mem_rsp_data_i
);

   tas_state_e state;
   logic       accept;
   logic       capture;

   tas_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .req_ready_i(mem_req_ready_i),
      .rsp_valid_i(mem_rsp_valid_i),
      .state_o    (state),
      .accept_o   (accept),
      .capture_o  (capture)
   );

   tas_datapath #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_MERGE(REG_MERGE)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_i  (accept),
      .capture_i (capture),
      .addr_i    (addr_i),
      .rsp_data_i(mem_rsp_data_i),
      .addr_o    (mem_req_addr_o),
      .wdata_o   (mem_req_wdata_o),
      .zero_o    (flag_o)
   );

   assign busy_o          = (state != TAS_IDLE);
   assign done_o          = (state == TAS_DONE);
   assign mem_lock_o      = tas_is_locked(state);
   assign mem_req_valid_o = tas_is_request(state);
   assign mem_req_we_o    = (state == TAS_WR_REQ);

endmodule

// File: rtl/tas_chk.sv
module tas_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              flag_o,
   input logic              mem_lock_o,
   input logic              mem_req_valid_o,
   input logic              mem_req_ready_i,
   input logic              mem_req_we_o,
   input logic [ADDR_W-1:0] mem_req_addr_o,
   input logic [DATA_W-1:0] mem_req_wdata_o,
   input logic              mem_rsp_valid_i,
   input logic [DATA_W-1:0] mem_rsp_data_i
);

   localparam logic [DATA_W-1:0] TOP_BIT = DATA_W'(1) << (DATA_W - 1);

   // Shadow of the port traffic: a read accepted and not yet answered,
   // and the byte that answered it.
   logic              rd_out_q;
   logic [DATA_W-1:0] seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_out_q <= 1'b0;
         seen_q   <= '0;
      end else begin
         if (mem_req_valid_o && mem_req_ready_i && !mem_req_we_o) rd_out_q <= 1'b1;
         else if (rd_out_q && mem_rsp_valid_i)                   rd_out_q <= 1'b0;
         if (rd_out_q && mem_rsp_valid_i) seen_q <= mem_rsp_data_i;
      end
   end

   assert_start_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> mem_req_valid_o && !mem_req_we_o && busy_o
                             && mem_req_addr_o == $past(addr_i));

   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o
         && $stable(mem_req_we_o) && $stable(mem_req_addr_o) && $stable(mem_req_wdata_o));

   assert_flag_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> flag_o == (seen_q == '0));

   assert_merge_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o && mem_req_we_o |-> mem_req_wdata_o == (seen_q | TOP_BIT));

   assert_lock_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o || rd_out_q |-> mem_lock_o);

   assert_lock_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o || done_o |-> !mem_lock_o);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);

   assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(mem_req_valid_o && mem_req_we_o && mem_req_ready_i));

   assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> $stable(mem_req_addr_o));

   assert_stray_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && mem_rsp_valid_i |=> $stable(flag_o));

endmodule

bind byte_tas_engine tas_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tas_chk (.*);

// File: tb/byte_tas_engine_tb_top.sv
module byte_tas_engine_tb_top;

   localparam int ADDR_W = 16;
   localparam int DATA_W = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic              busy_o, done_o, flag_o, mem_lock_o;
   logic              mem_req_valid_o, mem_req_we_o;
   logic              mem_req_ready_i = 1'b0;
   logic [ADDR_W-1:0] mem_req_addr_o;
   logic [DATA_W-1:0] mem_req_wdata_o;
   logic              mem_rsp_valid_i = 1'b0;
   logic [DATA_W-1:0] mem_rsp_data_i = '0;

   byte_tas_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (.*);

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [7:0] mem [16];

   // reference model
   int                ph = 0;
   logic [ADDR_W-1:0] m_addr = '0;
   logic [7:0]        m_byte = '0;
   logic              m_flag = 1'b0;

   // inputs applied for the coming edge and requests observed before it
   bit                a_start = 0, a_ready = 0, a_rspv = 0;
   logic [ADDR_W-1:0] a_addr = '0;
   logic [7:0]        a_rspd = '0;
   bit                s_valid = 0, s_we = 0;
   logic [ADDR_W-1:0] s_addr = '0;
   logic [7:0]        s_wdata = '0;

   // stimulus controls
   int                stall_cfg = 0, lat_cfg = 0, cyc = 0;
   bit                pend_start = 0, spur = 0;
   logic [ADDR_W-1:0] pend_addr = '0;
   bit                rd_pend = 0;
   int                rd_cnt = 0;
   logic [3:0]        rd_idx = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         ph = 0; m_flag = 0; m_addr = '0; rd_pend = 0; spur = 0;
         a_start = 0; a_ready = 0; a_rspv = 0; s_valid = 0; s_we = 0;
      end else begin
         // memory side of the last edge
         if (s_valid && a_ready) begin
            if (s_we) mem[s_addr[3:0]] = s_wdata;
            else begin rd_pend = 1; rd_cnt = lat_cfg; rd_idx = s_addr[3:0]; end
         end
         // reference step
         case (ph)
            0: if (a_start) begin ph = 1; m_addr = a_addr; end
            1: if (a_ready) ph = 2;
            2: if (a_rspv) begin m_byte = a_rspd; m_flag = (a_rspd == 8'h00); ph = 3; end
            3: if (a_ready) ph = 4;
            default: ph = 0;
         endcase
         // compare every cycle
         chk("R2 busy", busy_o, ph != 0);
         chk("R3 req_valid", mem_req_valid_o, ph == 1 || ph == 3);
         chk("R3 req_we", mem_req_we_o, ph == 3);
         chk("R6 lock", mem_lock_o, ph >= 1 && ph <= 3);
         chk("R7 done", done_o, ph == 4);
         chk("R4 flag", flag_o, m_flag);
         if (ph != 0) chk("R8 addr", mem_req_addr_o, m_addr);
         if (ph == 3) chk("R5 wdata", mem_req_wdata_o, m_byte | 8'h80);
         // drive the next edge
         cyc++;
         a_ready = ((cyc % (stall_cfg + 1)) == 0);
         a_start = pend_start; a_addr = pend_addr; pend_start = 0;
         a_rspv = 0;
         if (rd_pend) begin
            if (rd_cnt == 0) begin a_rspv = 1; a_rspd = mem[rd_idx]; rd_pend = 0; end
            else rd_cnt--;
         end else if (spur) begin
            a_rspv = 1; a_rspd = 8'h00; spur = 0;
         end
         s_valid = mem_req_valid_o; s_we = mem_req_we_o;
         s_addr = mem_req_addr_o; s_wdata = mem_req_wdata_o;
      end
      start_i = a_start; addr_i = a_addr; mem_req_ready_i = a_ready;
      mem_rsp_valid_i = a_rspv; mem_rsp_data_i = a_rspd;
   end

   task automatic run_op(input logic [ADDR_W-1:0] a, input int stall, input int lat,
                         input bit poke);
      logic [7:0] orig;
      bit seen_done;
      orig = mem[a[3:0]];
      seen_done = 0;
      stall_cfg = stall; lat_cfg = lat; pend_addr = a; pend_start = 1;
      for (int i = 0; i < 200; i++) begin
         @(posedge clk); #5;
         if (poke && i == 2 && busy_o) begin pend_addr = a ^ 16'h0005; pend_start = 1; end
         if (done_o) begin seen_done = 1; break; end
      end
      chk("R7 done seen", seen_done, 1'b1);
      chk("R4 flag at done", flag_o, orig == 8'h00);
      @(posedge clk); #5;
      chk("R7 done low after", done_o, 1'b0);
      chk("R7 idle after done", busy_o, 1'b0);
      @(posedge clk); #5;
      chk("R5 memory byte", mem[a[3:0]], orig | 8'h80);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 8'(i * 8'h13 + 8'h21);
      mem[0] = 8'h00; mem[3] = 8'h00; mem[5] = 8'h80; mem[7] = 8'h7F;
      mem[9] = 8'h01; mem[12] = 8'h00;
      repeat (3) @(posedge clk);
      #5;
      chk("R1 busy", busy_o, 0);
      chk("R1 done", done_o, 0);
      chk("R1 lock", mem_lock_o, 0);
      chk("R1 req_valid", mem_req_valid_o, 0);
      chk("R1 flag", flag_o, 0);
      rst_n = 1'b1;
      @(posedge clk); #5;
      chk("R1 idle after release", busy_o, 0);

      run_op(16'h0003, 0, 0, 0);          // zero byte: claimed
      run_op(16'h0003, 0, 0, 0);          // now 0x80: already taken
      run_op(16'h1237, 2, 3, 0);          // 0x7F -> 0xFF under stalls
      run_op(16'h0005, 1, 1, 1);          // start while busy (R8)
      chk("R8 other byte untouched", mem[0], 8'h00);

      // R9: stray response while idle, flag currently 0
      spur = 1;
      repeat (4) @(posedge clk);
      #5;
      chk("R9 flag held after stray rsp", flag_o, 0);
      chk("R9 no access from stray rsp", busy_o, 0);

      run_op(16'h000C, 3, 5, 0);          // zero byte, long latency
      run_op(16'h0009, 0, 0, 0);          // 0x01 -> 0x81 straight after
      repeat (5) @(posedge clk);
      #5;
      chk("R9 flag holds between ops", flag_o, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog R7 actual=hung expected=complete");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule